// File: doc/BRIEF.md
# Slotted Ring Node Interface

This block is the per-cell attachment point onto a unidirectional, slotted, pipelined ring. The ring carries memory request, response and broadcast messages between caching cells. The node owns one slot position. Each cycle it can take the message arriving from the upstream neighbour and present a message to the downstream neighbour. A message advances only when the position ahead of it is free; otherwise it holds in place. Each slot carries a header (message type, originating node, subpage address, requested coherence state) and a subpage payload, which moves as one wide transfer.

As messages pass, the node checks foreign requests against a local cache lookup port. When the local cache holds a valid copy, the node rewrites the request, in its own slot, into a response carrying the cached data. The node collects the response to its own single outstanding request and completes the fill. A request of its own that comes back unanswered after a full lap is a global miss, and the node raises a fault pulse. A broadcast from another node is copied when the local cache has space allocated for that subpage but holds no valid copy, and only if the cell is not busy. Locally generated requests and broadcasts go into the slot only when the slot is empty. Higher ring levels, routing between rings and paging are outside this block. The slot count of the ring is a parameter of the surrounding ring, 13 by default.

Top module: `ring_node_if`

## Requirements
- R1: After reset, dn_valid, fill_valid, fault and snoop_valid are all 0, and a local request is accepted (tx_ready is 1 for tx_type 2'b01).
- R2: up_ready equals (!dn_valid || dn_ready). While dn_valid is 1 and dn_ready is 0, every dn_* field holds its value into the next cycle.
- R3: A local message is accepted (tx_ready=1) only in a cycle where the slot advances and no upstream message is being kept in the slot. A passing message has priority over local insertion.
- R4: A request (type 2'b01) from another node, accepted while lk_hit=1, leaves the node in the next cycle as a response (type 2'b10). It keeps its source, address and state fields, and its payload is lk_data.
- R5: A request from another node, accepted while lk_hit=0, is forwarded with all fields unchanged.
- R6: A response (type 2'b10) whose source equals the node's ID and whose address matches the pending request gives fill_valid=1 with fill_data equal to its payload in the next cycle. It is removed from the ring and the pending request is retired.
- R7: A request whose source equals the node's ID is removed from the ring when it arrives. If its address matches the pending request, fault pulses for one cycle in the next cycle and the pending request is retired.
- R8: At most one request of the node's own is outstanding. While one is pending, tx_ready is 0 for tx_type 2'b01 but stays available for broadcasts (2'b11). The local port never accepts tx_type 2'b10 or 2'b00.
- R9: A broadcast (type 2'b11) from another node, accepted with lk_alloc=1, lk_hit=0 and snoop_busy=0, gives snoop_valid=1 with snoop_addr and snoop_data equal to its fields in the next cycle. The broadcast itself is forwarded unchanged.
- R10: A broadcast from another node with snoop_busy=1, lk_hit=1 or lk_alloc=0 gives no snoop_valid and is still forwarded unchanged.
- R11: A broadcast whose source equals the node's ID is removed from the ring.
- R12: An inserted local message leaves with source equal to the node's ID and the type, address, state and payload given on the tx_* port.
- R13: Responses that are not for the node's pending request pass unchanged, and lk_addr always equals up_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream slot holds a message |
| up_ready | output | 1 | Node can take the upstream message |
| up_type | input | 2 | Message type: 01 request, 10 response, 11 broadcast |
| up_src | input | ID_W | Originating node |
| up_addr | input | ADDR_W | Subpage address |
| up_state | input | 2 | Requested coherence state |
| up_data | input | DATA_W | Subpage payload |
| dn_valid | output | 1 | Downstream slot holds a message |
| dn_ready | input | 1 | Downstream position is free |
| dn_type | output | 2 | Message type |
| dn_src | output | ID_W | Originating node |
| dn_addr | output | ADDR_W | Subpage address |
| dn_state | output | 2 | Requested coherence state |
| dn_data | output | DATA_W | Subpage payload |
| tx_valid | input | 1 | Local message waiting for insertion |
| tx_ready | output | 1 | Local message is inserted this cycle |
| tx_type | input | 2 | Local message type (01 or 11) |
| tx_addr | input | ADDR_W | Local message address |
| tx_state | input | 2 | Local requested state |
| tx_data | input | DATA_W | Local payload |
| lk_addr | output | ADDR_W | Address presented to the local cache |
| lk_alloc | input | 1 | Local cache has space allocated for lk_addr |
| lk_hit | input | 1 | Local cache holds a valid copy of lk_addr |
| lk_data | input | DATA_W | Local cache data for lk_addr |
| snoop_busy | input | 1 | Cell too busy to take a broadcast copy |
| fill_valid | output | 1 | Own request completed |
| fill_data | output | DATA_W | Data of the completed fill |
| fault | output | 1 | Own request returned unanswered |
| snoop_valid | output | 1 | Broadcast copy taken |
| snoop_addr | output | ADDR_W | Address of the taken copy |
| snoop_data | output | DATA_W | Data of the taken copy |

## Verification
On every cycle, the assertions check that a stalled slot holds still, that a hit on a foreign request becomes a response, that only one own request is outstanding, that a busy cell never takes a snoop copy, and that fill and fault never coincide. The bench scenarios show the payload contents: response data taken from the lookup port, the fill data and the fault after a lap. They also show which messages are removed and which pass, and that insertion waits for an empty slot. These depend on the message history, which only a reference model tracking the pending request can judge.

// File: rtl/ring_node_if.sv
module ring_node_if #(
  parameter int ID_W   = 5,
  parameter int MY_ID  = 0,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [1:0]        up_type,
  input  logic [ID_W-1:0]   up_src,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [1:0]        up_state,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [1:0]        dn_type,
  output logic [ID_W-1:0]   dn_src,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [1:0]        dn_state,
  output logic [DATA_W-1:0] dn_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [1:0]        tx_type,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [1:0]        tx_state,
  input  logic [DATA_W-1:0] tx_data,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_alloc,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_data,
  input  logic              snoop_busy,
  output logic              fill_valid,
  output logic [DATA_W-1:0] fill_data,
  output logic              fault,
  output logic              snoop_valid,
  output logic [ADDR_W-1:0] snoop_addr,
  output logic [DATA_W-1:0] snoop_data
);
  localparam logic [1:0] T_REQ = 2'b01;
  localparam logic [1:0] T_RSP = 2'b10;
  localparam logic [1:0] T_BC  = 2'b11;
  localparam logic [ID_W-1:0] SELF = ID_W'(MY_ID);

  logic              pend;
  logic [ADDR_W-1:0] pend_addr;

  logic adv, take, mine, hit_pend, own_rsp, own_req, own_bc, serve, snoop, keep, tx_go;

  assign adv      = !dn_valid || dn_ready;
  assign up_ready = adv;
  assign lk_addr  = up_addr;
  assign take     = up_valid && adv;
  assign mine     = up_src == SELF;
  assign hit_pend = pend && (up_addr == pend_addr);
  assign own_rsp  = take && up_type == T_RSP && mine && hit_pend;
  assign own_req  = take && up_type == T_REQ && mine;
  assign own_bc   = take && up_type == T_BC && mine;
  assign serve    = take && up_type == T_REQ && !mine && lk_hit;
  assign snoop    = take && up_type == T_BC && !mine && lk_alloc && !lk_hit && !snoop_busy;
  assign keep     = take && !own_rsp && !own_req && !own_bc;
  assign tx_ready = adv && !keep && (tx_type == T_BC || (tx_type == T_REQ && !pend));
  assign tx_go    = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_type  <= '0;
      dn_src   <= '0;
      dn_addr  <= '0;
      dn_state <= '0;
      dn_data  <= '0;
    end else if (adv) begin
      dn_valid <= keep || tx_go;
      if (keep) begin
        dn_type  <= serve ? T_RSP : up_type;
        dn_src   <= up_src;
        dn_addr  <= up_addr;
        dn_state <= up_state;
        dn_data  <= serve ? lk_data : up_data;
      end else if (tx_go) begin
        dn_type  <= tx_type;
        dn_src   <= SELF;
        dn_addr  <= tx_addr;
        dn_state <= tx_state;
        dn_data  <= tx_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend        <= 1'b0;
      pend_addr   <= '0;
      fill_valid  <= 1'b0;
      fill_data   <= '0;
      fault       <= 1'b0;
      snoop_valid <= 1'b0;
      snoop_addr  <= '0;
      snoop_data  <= '0;
    end else begin
      fill_valid  <= own_rsp;
      fault       <= own_req && hit_pend;
      snoop_valid <= snoop;
      if (own_rsp) fill_data <= up_data;
      if (snoop) begin
        snoop_addr <= up_addr;
        snoop_data <= up_data;
      end
      if (tx_go && tx_type == T_REQ) begin
        pend      <= 1'b1;
        pend_addr <= tx_addr;
      end else if (own_rsp || (own_req && hit_pend)) begin
        pend <= 1'b0;
      end
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_type) && $stable(dn_src)
      && $stable(dn_addr) && $stable(dn_state) && $stable(dn_data));

  a_r4_serve: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready && up_type == T_REQ && up_src != SELF && lk_hit
      |=> dn_valid && dn_type == T_RSP);

  a_r8_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    pend && tx_type == T_REQ |-> !tx_ready);

  a_r9_no_snoop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_busy |=> !snoop_valid);

  a_r6_fill_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fault));

  a_r6_fill_retires: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !pend);
endmodule

// File: tb/ring_node_if_tb.sv
module ring_node_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 5, MY_ID = 3, ADDR_W = 20, DATA_W = 64;
  localparam int RING_SLOTS = 13;
  localparam logic [1:0] T_REQ = 2'b01, T_RSP = 2'b10, T_BC = 2'b11;

  logic clk = 0, rst_n = 0;
  logic up_valid = 0, up_ready;
  logic [1:0] up_type = 0, up_state = 0;
  logic [ID_W-1:0] up_src = 0;
  logic [ADDR_W-1:0] up_addr = 0;
  logic [DATA_W-1:0] up_data = 0;
  logic dn_valid, dn_ready = 1;
  logic [1:0] dn_type, dn_state;
  logic [ID_W-1:0] dn_src;
  logic [ADDR_W-1:0] dn_addr;
  logic [DATA_W-1:0] dn_data;
  logic tx_valid = 0, tx_ready;
  logic [1:0] tx_type = 0, tx_state = 0;
  logic [ADDR_W-1:0] tx_addr = 0;
  logic [DATA_W-1:0] tx_data = 0;
  logic [ADDR_W-1:0] lk_addr;
  logic lk_alloc = 0, lk_hit = 0, snoop_busy = 0;
  logic [DATA_W-1:0] lk_data = 0;
  logic fill_valid, fault, snoop_valid;
  logic [DATA_W-1:0] fill_data, snoop_data;
  logic [ADDR_W-1:0] snoop_addr;

  ring_node_if #(.ID_W(ID_W), .MY_ID(MY_ID), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  bit m_vld, m_pend, m_fill, m_fault, m_snoop;
  logic [1:0] m_type, m_state;
  logic [ID_W-1:0] m_src;
  logic [ADDR_W-1:0] m_addr, m_paddr, m_saddr;
  logic [DATA_W-1:0] m_data, m_fdata, m_sdata;

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_txr(input bit vld);
    bit adv, mine, keep;
    adv = !vld || dn_ready;
    mine = up_src == ID_W'(MY_ID);
    keep = up_valid && adv &&
      !(mine && (up_type == T_REQ || up_type == T_BC ||
        (up_type == T_RSP && m_pend && up_addr == m_paddr)));
    return adv && !keep && (tx_type == T_BC || (tx_type == T_REQ && !m_pend));
  endfunction

  task automatic step(input string tag);
    bit adv, mine, txr, hitp;
    #1;
    adv = !m_vld || dn_ready;
    txr = exp_txr(m_vld);
    chk(up_ready == adv, "R2 up_ready", up_ready, adv);
    chk(tx_ready == txr, "R3 tx_ready", tx_ready, txr);
    chk(lk_addr == up_addr, "R13 lk_addr", lk_addr, up_addr);
    mine = up_src == ID_W'(MY_ID);
    hitp = m_pend && up_addr == m_paddr;
    m_fill = 0; m_fault = 0; m_snoop = 0;
    if (adv) begin
      if (up_valid && mine && up_type == T_RSP && hitp) begin
        m_fill = 1; m_fdata = up_data; m_pend = 0; m_vld = 0;
      end else if (up_valid && mine && up_type == T_REQ) begin
        if (hitp) begin m_fault = 1; m_pend = 0; end
        m_vld = 0;
      end else if (up_valid && mine && up_type == T_BC) begin
        m_vld = 0;
      end else if (up_valid) begin
        m_vld = 1; m_src = up_src; m_addr = up_addr; m_state = up_state;
        m_type = up_type; m_data = up_data;
        if (up_type == T_REQ && lk_hit) begin m_type = T_RSP; m_data = lk_data; end
        if (up_type == T_BC && lk_alloc && !lk_hit && !snoop_busy) begin
          m_snoop = 1; m_saddr = up_addr; m_sdata = up_data;
        end
      end else m_vld = 0;
      if (!m_vld && tx_valid && txr) begin
        m_vld = 1; m_src = ID_W'(MY_ID); m_addr = tx_addr; m_state = tx_state;
        m_type = tx_type; m_data = tx_data;
        if (tx_type == T_REQ) begin m_pend = 1; m_paddr = tx_addr; end
      end
    end
    @(posedge clk); #1;
    chk(dn_valid == m_vld, {tag, " dn_valid"}, dn_valid, m_vld);
    if (m_vld) begin
      chk(dn_type == m_type && dn_src == m_src && dn_addr == m_addr && dn_state == m_state,
          {tag, " dn header"}, {dn_type, dn_src, dn_addr, dn_state}, {m_type, m_src, m_addr, m_state});
      chk(dn_data == m_data, {tag, " dn_data"}, dn_data, m_data);
    end
    chk(fill_valid == m_fill, {tag, " fill_valid"}, fill_valid, m_fill);
    if (m_fill) chk(fill_data == m_fdata, {tag, " fill_data"}, fill_data, m_fdata);
    chk(fault == m_fault, {tag, " fault"}, fault, m_fault);
    chk(snoop_valid == m_snoop, {tag, " snoop_valid"}, snoop_valid, m_snoop);
    if (m_snoop) chk(snoop_addr == m_saddr && snoop_data == m_sdata, {tag, " snoop"}, snoop_data, m_sdata);
  endtask

  task automatic up_msg(input bit v, input logic [1:0] t, input int src, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    up_valid = v; up_type = t; up_src = ID_W'(src); up_addr = a; up_state = 2'd2; up_data = d;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    m_vld = 0; m_pend = 0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    // R1 reset state
    chk(!dn_valid && !fill_valid && !fault && !snoop_valid, "R1 reset outputs", {dn_valid, fill_valid, fault, snoop_valid}, 0);
    tx_type = T_REQ; #1;
    chk(tx_ready == 1, "R1 request accepted", tx_ready, 1);
    // R12 insert own request
    tx_valid = 1; tx_type = T_REQ; tx_addr = 20'h00A1; tx_state = 2'd1; tx_data = 64'h1111;
    step("R12");
    chk(dn_src == ID_W'(MY_ID) && dn_addr == 20'h00A1 && dn_type == T_REQ, "R12 inserted fields", dn_addr, 20'h00A1);
    // R8 second request held, broadcast allowed
    tx_addr = 20'h00B2; #1;
    chk(tx_ready == 0, "R8 second request held", tx_ready, 0);
    tx_type = T_BC; tx_data = 64'hBCBC;
    step("R8");
    chk(dn_type == T_BC, "R8 broadcast inserted", dn_type, T_BC);
    tx_valid = 0;
    // R4 foreign request served
    up_msg(1, T_REQ, 5, 20'h0C00, 64'h0); lk_hit = 1; lk_data = 64'hDEAD_BEEF;
    step("R4");
    chk(dn_type == T_RSP && dn_data == 64'hDEAD_BEEF && dn_src == 5, "R4 response built", dn_data, 64'hDEAD_BEEF);
    // R5 foreign request missed
    lk_hit = 0; up_msg(1, T_REQ, 5, 20'h0C01, 64'h5555);
    step("R5");
    chk(dn_type == T_REQ && dn_data == 64'h5555, "R5 forwarded", dn_data, 64'h5555);
    // R3 passing message beats local insert; R13 foreign response passes
    up_msg(1, T_RSP, 7, 20'h0D00, 64'h7777); tx_valid = 1; tx_type = T_BC; #1;
    chk(tx_ready == 0, "R3 insert blocked by passing message", tx_ready, 0);
    step("R3");
    chk(dn_type == T_RSP && dn_src == 7 && dn_data == 64'h7777, "R13 foreign response passes", dn_data, 64'h7777);
    tx_valid = 0;
    // R6 own response
    up_msg(1, T_RSP, MY_ID, 20'h00A1, 64'hF111);
    step("R6");
    chk(fill_valid && fill_data == 64'hF111 && !dn_valid, "R6 fill and removal", fill_data, 64'hF111);
    up_msg(0, T_REQ, 0, 0, 0); tx_type = T_REQ; #1;
    chk(tx_ready == 1, "R6 pending retired", tx_ready, 1);
    // R7 own request returns unanswered after a lap
    tx_valid = 1; tx_addr = 20'h00C3;
    step("R7");
    tx_valid = 0;
    for (int i = 0; i < RING_SLOTS - 1; i++) step("R7");
    up_msg(1, T_REQ, MY_ID, 20'h00C3, 64'h0);
    step("R7");
    chk(fault && !dn_valid, "R7 fault and removal", fault, 1);
    up_msg(0, T_REQ, 0, 0, 0);
    step("R7");
    chk(!fault, "R7 fault single pulse", fault, 0);
    // R9 snoop taken
    up_msg(1, T_BC, 6, 20'h0E00, 64'hABCD); lk_alloc = 1; lk_hit = 0; snoop_busy = 0;
    step("R9");
    chk(snoop_valid && snoop_addr == 20'h0E00 && dn_type == T_BC, "R9 snoop and pass", snoop_data, 64'hABCD);
    // R10 busy cell skips
    snoop_busy = 1;
    step("R10");
    chk(!snoop_valid && dn_valid && dn_data == 64'hABCD, "R10 busy no snoop", snoop_valid, 0);
    snoop_busy = 0; lk_hit = 1;
    step("R10");
    chk(!snoop_valid, "R10 valid copy no snoop", snoop_valid, 0);
    lk_hit = 0; lk_alloc = 0;
    // R11 own broadcast removed
    up_msg(1, T_BC, MY_ID, 20'h0F00, 64'h1);
    step("R11");
    chk(!dn_valid, "R11 own broadcast removed", dn_valid, 0);
    // R2 hold under stall
    up_msg(1, T_REQ, 9, 20'h0101, 64'h99);
    step("R2");
    dn_ready = 0; up_msg(1, T_REQ, 10, 20'h0202, 64'hAA);
    step("R2");
    chk(dn_valid && dn_addr == 20'h0101, "R2 held under stall", dn_addr, 20'h0101);
    dn_ready = 1;
    step("R2");
    chk(dn_addr == 20'h0202, "R2 resumes", dn_addr, 20'h0202);
    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [ADDR_W-1:0] a;
      a = ($urandom % 4 == 0 && m_pend) ? m_paddr : ADDR_W'($urandom % 8);
      up_msg($urandom % 3 != 0, 2'($urandom % 3 + 1), ($urandom % 3 == 0) ? MY_ID : $urandom % 8, a, {$urandom, $urandom});
      dn_ready = $urandom % 4 != 0;
      tx_valid = $urandom % 2; tx_type = ($urandom % 2) ? T_REQ : T_BC;
      tx_addr = ADDR_W'($urandom % 8); tx_state = 2'($urandom); tx_data = {$urandom, $urandom};
      lk_alloc = $urandom % 2; lk_hit = $urandom % 2; lk_data = {$urandom, $urandom};
      snoop_busy = $urandom % 3 == 0;
      step("R4 R6 R7 R9 random");
    end
    finish_run();
  end
endmodule